// File: doc/BRIEF.md
# PCIe PHY and Controller Reset Release Sequencer

This block takes a PCIe PHY and its controller out of reset in a fixed, timed order. All reset outputs are active low. The endpoint reset line (`perst_n`) stays low across the early stages. It goes high only after the PLL has reported lock and the controller sideband interface has had time to settle. A pulse on `start` runs the sequence. `done` reports that the controller primary interface has been released. If lock never arrives, the sequencer stops and raises `lock_err`.

Each delay is a parameter in microseconds. It is turned into a clock-cycle count through `CLK_PER_US`. A single shared counter times every stage and restarts on each state change. The PLL-lock input passes through a two-flop synchronizer before the state machine uses it.

States, in order:

| State | Meaning |
|-------|---------|
| ST_IDLE | After reset. Everything is asserted. |
| ST_HOLD | One cycle with everything asserted. |
| ST_CMN | Common lane is released; the common-lane delay runs. |
| ST_LOCK | Waiting for lock, with a timeout. |
| ST_SBI | Controller sideband is released; its delay runs. |
| ST_PERST | `perst_n` is high; the post-release delay runs. |
| ST_DONE | Final state. |
| ST_FAIL | Lock timeout. |

Transitions:

| From | To | Condition |
|------|----|-----------|
| ST_IDLE, ST_DONE or ST_FAIL | ST_HOLD | `start` |
| ST_HOLD | ST_CMN | Always, one cycle later |
| ST_CMN | ST_LOCK | Common-lane delay expires |
| ST_LOCK | ST_SBI | Synchronized lock is seen |
| ST_LOCK | ST_FAIL | Timeout expires; lock wins a tie |
| ST_SBI | ST_PERST | Sideband delay expires |
| ST_PERST | ST_DONE | Post-release delay expires |

Top module: `pcie_rst_seq`

## Requirements
- R1: An asynchronous low on `rst_n` drives every reset output, `done` and `lock_err` to 0 at once. The sequencer then stays idle until `start`.
- R2: The edge that samples `start` in ST_IDLE, ST_DONE or ST_FAIL enters ST_HOLD. In ST_HOLD every output is 0. `perst_n` stays 0 until R7 releases it.
- R3: `phy_cmn_rst_n` goes high on the edge after ST_HOLD. It stays high for exactly CMN_DLY_US*CLK_PER_US cycles before R4.
- R4: `phy_side_rst_n` and `ctl_main_rst_n` go high on the same edge, when the common-lane delay ends.
- R5: A rise of `pll_lock` sampled at edge e is seen by the state machine after two flops. `ctl_sbi_rst_n` then goes high at edge max(e+2, first edge in ST_LOCK + 1).
- R6: If lock has not been seen within LOCK_TMO_US*CLK_PER_US cycles of ST_LOCK, `lock_err` goes to 1. `perst_n`, `ctl_sbi_rst_n` and `ctl_prim_rst_n` stay 0. Lock seen in the last cycle of the window wins.
- R7: `perst_n` goes high exactly SBI_DLY_US*CLK_PER_US cycles after `ctl_sbi_rst_n`.
- R8: `ctl_prim_rst_n` and `done` go high exactly PERST_DLY_US*CLK_PER_US cycles after `perst_n`.
- R9: The parameters must satisfy PERST_MIN_US <= CMN_DLY_US + LOCK_TMO_US + SBI_DLY_US. This is checked at elaboration.
- R10: A new `start` from ST_DONE or ST_FAIL clears `done` and `lock_err`. It reasserts every reset on the next edge and runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins or restarts the sequence |
| pll_lock | input | 1 | PLL lock, asynchronous to `clk` |
| perst_n | output | 1 | Endpoint reset, active low |
| phy_cmn_rst_n | output | 1 | PHY common-lane reset, active low |
| phy_side_rst_n | output | 1 | PHY sideband reset, active low |
| ctl_main_rst_n | output | 1 | Controller main reset, active low |
| ctl_sbi_rst_n | output | 1 | Controller sideband-interface reset, active low |
| ctl_prim_rst_n | output | 1 | Controller primary-interface reset, active low |
| done | output | 1 | Sequence complete |
| lock_err | output | 1 | Lock timeout |

## Verification
Count edges from the one that samples `start`, called edge 0. ST_HOLD shows after edge 0 and the common-lane release after edge 1. The sideband and main releases follow after edge 1 + CMN cycles. A lock raised before edge e takes effect at edge max(e+2, lock-wait entry + 1); the later releases follow that edge by the sideband delay and by the sideband delay plus the post-release delay. The bench sweeps the lock arrival across the whole timeout window and beyond it. Each run derives these edge numbers arithmetically and compares every output at the negative edge after each posedge, so each value is sampled in the cycle it is due.

// File: rtl/pcie_rst_seq_pkg.sv
package pcie_rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_CMN,
        ST_LOCK,
        ST_SBI,
        ST_PERST,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    typedef struct packed {
        logic perst_n;
        logic cmn_n;
        logic side_n;
        logic main_n;
        logic sbi_n;
        logic prim_n;
        logic done;
        logic err;
    } rst_vec_t;

endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/stage_timer.sv
module stage_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    localparam logic [CW-1:0] CNT_MAX = '1;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (restart)        cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign hit = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/pcie_rst_seq.sv
module pcie_rst_seq
    import pcie_rst_seq_pkg::*;
#(
    parameter int CLK_PER_US   = 100,
    parameter int CMN_DLY_US   = 2,
    parameter int SBI_DLY_US   = 20,
    parameter int PERST_DLY_US = 10,
    parameter int LOCK_TMO_US  = 100,
    parameter int PERST_MIN_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pll_lock,
    output logic perst_n,
    output logic phy_cmn_rst_n,
    output logic phy_side_rst_n,
    output logic ctl_main_rst_n,
    output logic ctl_sbi_rst_n,
    output logic ctl_prim_rst_n,
    output logic done,
    output logic lock_err
);
    localparam int CMN_CYC   = CMN_DLY_US * CLK_PER_US;
    localparam int SBI_CYC   = SBI_DLY_US * CLK_PER_US;
    localparam int PERST_CYC = PERST_DLY_US * CLK_PER_US;
    localparam int LOCK_CYC  = LOCK_TMO_US * CLK_PER_US;
    localparam int MAX_AB    = (CMN_CYC > SBI_CYC) ? CMN_CYC : SBI_CYC;
    localparam int MAX_CD    = (PERST_CYC > LOCK_CYC) ? PERST_CYC : LOCK_CYC;
    localparam int MAX_CYC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW        = $clog2(MAX_CYC + 2);

    // R9: parameter relation, checked at elaboration
    initial begin
        assert_perst_min_R9: assert (PERST_MIN_US <= CMN_DLY_US + LOCK_TMO_US + SBI_DLY_US)
            else $error("PERST_MIN_US exceeds common-lane + lock + sideband delays");
    end

    seq_state_t st_q, st_d;
    rst_vec_t   out_q, out_d;
    logic       lock_s;
    logic       tmr_hit;
    logic       tmr_restart;
    logic [CW-1:0] tmr_limit;

    lock_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pll_lock),
        .sync_out (lock_s)
    );

    always_comb begin
        unique case (st_q)
            ST_CMN:   tmr_limit = CW'(CMN_CYC);
            ST_LOCK:  tmr_limit = CW'(LOCK_CYC);
            ST_SBI:   tmr_limit = CW'(SBI_CYC);
            ST_PERST: tmr_limit = CW'(PERST_CYC);
            default:  tmr_limit = '1;
        endcase
    end

    assign tmr_restart = (st_d != st_q);

    stage_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .limit   (tmr_limit),
        .hit     (tmr_hit)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_DONE, ST_FAIL: if (start) st_d = ST_HOLD;
            ST_HOLD:  st_d = ST_CMN;
            ST_CMN:   if (tmr_hit) st_d = ST_LOCK;
            ST_LOCK: begin
                if (lock_s)       st_d = ST_SBI;
                else if (tmr_hit) st_d = ST_FAIL;
            end
            ST_SBI:   if (tmr_hit) st_d = ST_PERST;
            ST_PERST: if (tmr_hit) st_d = ST_DONE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // output decode of the next state
    always_comb begin
        out_d = '0;
        unique case (st_d)
            ST_IDLE, ST_HOLD: out_d = '0;
            ST_CMN: out_d.cmn_n = 1'b1;
            ST_LOCK: begin
                out_d.cmn_n  = 1'b1;
                out_d.side_n = 1'b1;
                out_d.main_n = 1'b1;
            end
            ST_SBI: begin
                out_d.cmn_n  = 1'b1;
                out_d.side_n = 1'b1;
                out_d.main_n = 1'b1;
                out_d.sbi_n  = 1'b1;
            end
            ST_PERST: begin
                out_d.cmn_n   = 1'b1;
                out_d.side_n  = 1'b1;
                out_d.main_n  = 1'b1;
                out_d.sbi_n   = 1'b1;
                out_d.perst_n = 1'b1;
            end
            ST_DONE: begin
                out_d.cmn_n   = 1'b1;
                out_d.side_n  = 1'b1;
                out_d.main_n  = 1'b1;
                out_d.sbi_n   = 1'b1;
                out_d.perst_n = 1'b1;
                out_d.prim_n  = 1'b1;
                out_d.done    = 1'b1;
            end
            ST_FAIL: begin
                out_d.cmn_n  = 1'b1;
                out_d.side_n = 1'b1;
                out_d.main_n = 1'b1;
                out_d.err    = 1'b1;
            end
            default: out_d = '0;
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign perst_n        = out_q.perst_n;
    assign phy_cmn_rst_n  = out_q.cmn_n;
    assign phy_side_rst_n = out_q.side_n;
    assign ctl_main_rst_n = out_q.main_n;
    assign ctl_sbi_rst_n  = out_q.sbi_n;
    assign ctl_prim_rst_n = out_q.prim_n;
    assign done           = out_q.done;
    assign lock_err       = out_q.err;

    // ordering checks
    assert_side_after_cmn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phy_side_rst_n |-> phy_cmn_rst_n);
    assert_side_main_together_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_side_rst_n) |-> $rose(ctl_main_rst_n));
    assert_sbi_after_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_sbi_rst_n) |-> $past(lock_s));
    assert_perst_after_sbi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        perst_n |-> (ctl_sbi_rst_n && ctl_main_rst_n));
    assert_prim_after_perst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_prim_rst_n |-> perst_n);
    assert_err_holds_perst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |-> (!perst_n && !ctl_sbi_rst_n && !done));
    assert_hold_all_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |-> (out_q == '0));
endmodule

// File: tb/pcie_rst_seq_test.sv
`timescale 1ns/1ps
module pcie_rst_seq_test;
    localparam int CPU = 2, CMN = 2, SBI = 3, PDL = 1, TMO = 5, PMIN = 4;
    localparam int CMN_C = CMN*CPU, SBI_C = SBI*CPU, PDL_C = PDL*CPU, TMO_C = TMO*CPU;
    localparam int LOCK_IN = 1 + CMN_C;          // edge that enters lock wait
    localparam int TMO_EDGE = LOCK_IN + TMO_C;   // edge that times out

    logic clk = 0, rst_n = 0, start = 0, pll_lock = 0;
    logic perst_n, phy_cmn_rst_n, phy_side_rst_n, ctl_main_rst_n;
    logic ctl_sbi_rst_n, ctl_prim_rst_n, done, lock_err;
    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pcie_rst_seq #(.CLK_PER_US(CPU), .CMN_DLY_US(CMN), .SBI_DLY_US(SBI),
        .PERST_DLY_US(PDL), .LOCK_TMO_US(TMO), .PERST_MIN_US(PMIN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pll_lock(pll_lock),
        .perst_n(perst_n), .phy_cmn_rst_n(phy_cmn_rst_n),
        .phy_side_rst_n(phy_side_rst_n), .ctl_main_rst_n(ctl_main_rst_n),
        .ctl_sbi_rst_n(ctl_sbi_rst_n), .ctl_prim_rst_n(ctl_prim_rst_n),
        .done(done), .lock_err(lock_err));

    task automatic chk(string tag, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: got %b expected %b", tag, what, cyc, got, exp);
        end
    endtask

    // bit order: perst, cmn, side, main, sbi, prim, done, err
    function automatic logic [7:0] expv(int k, int tl, bit ok);
        if (k == 0) return 8'b0000_0000;
        if (k < LOCK_IN) return 8'b0100_0000;
        if (!ok) return (k < TMO_EDGE) ? 8'b0111_0000 : 8'b0111_0001;
        if (k < tl) return 8'b0111_0000;
        if (k < tl + SBI_C) return 8'b0111_1000;
        if (k < tl + SBI_C + PDL_C) return 8'b1111_1000;
        return 8'b1111_1110;
    endfunction

    task automatic chk_all(int k, logic [7:0] e);
        logic [7:0] g;
        g = {perst_n, phy_cmn_rst_n, phy_side_rst_n, ctl_main_rst_n,
             ctl_sbi_rst_n, ctl_prim_rst_n, done, lock_err};
        chk(k == 0 ? "R2" : "R7", "perst_n", g[7], e[7]);
        chk(k == 0 ? "R2" : "R3", "phy_cmn_rst_n", g[6], e[6]);
        chk(k == 0 ? "R2" : "R4", "phy_side_rst_n", g[5], e[5]);
        chk(k == 0 ? "R2" : "R4", "ctl_main_rst_n", g[4], e[4]);
        chk(k == 0 ? "R2" : "R5", "ctl_sbi_rst_n", g[3], e[3]);
        chk(k == 0 ? "R2" : "R8", "ctl_prim_rst_n", g[2], e[2]);
        chk(k == 0 ? "R10" : "R8", "done", g[1], e[1]);
        chk(k == 0 ? "R10" : "R6", "lock_err", g[0], e[0]);
    endtask

    // one sequence with lock raised before edge le (relative to start edge 0)
    task automatic run_seq(int le);
        int tl, last;
        bit ok;
        tl = (le + 2 > LOCK_IN + 1) ? le + 2 : LOCK_IN + 1;
        ok = (tl <= TMO_EDGE);
        last = ok ? tl + SBI_C + PDL_C + 2 : TMO_EDGE + 2;
        @(negedge clk);
        start = 1;
        pll_lock = (le == 0);
        for (int k = 0; k <= last; k++) begin
            @(posedge clk);
            @(negedge clk);
            start = 0;
            pll_lock = (k + 1 >= le);
            chk_all(k, expv(k, tl, ok));
        end
    endtask

    initial begin
        #1;
        // R1: outputs low during reset
        chk("R1", "perst_n in reset", perst_n, 1'b0);
        chk("R1", "done in reset", done, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R1", "idle cmn", phy_cmn_rst_n, 1'b0);
        chk("R1", "idle err", lock_err, 1'b0);
        // R9: parameter relation of this configuration
        chk("R9", "perst min relation", 1'(PMIN <= CMN + TMO + SBI), 1'b1);
        // sweep lock arrival across and beyond the timeout window (R5, R6, R10)
        for (int le = 0; le <= TMO_EDGE + 2; le++) run_seq(le);
        run_seq(LOCK_IN + 3);
        // R1: async reset in the middle of a sequence
        @(negedge clk);
        start = 1; pll_lock = 0;
        @(negedge clk);
        start = 0;
        repeat (CMN_C + 2) @(negedge clk);
        chk("R1", "side released before reset", phy_side_rst_n, 1'b1);
        #0.7 rst_n = 0;
        #0.3;
        chk("R1", "async cmn", phy_cmn_rst_n, 1'b0);
        chk("R1", "async side", phy_side_rst_n, 1'b0);
        chk("R1", "async main", ctl_main_rst_n, 1'b0);
        @(negedge clk);
        rst_n = 1; pll_lock = 1;
        repeat (CMN_C + 4) @(negedge clk);
        chk("R1", "stays idle cmn", phy_cmn_rst_n, 1'b0);
        chk("R1", "stays idle sbi", ctl_sbi_rst_n, 1'b0);
        chk("R1", "stays idle done", done, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule